// File: doc/BRIEF.md
# Lower Bound Check Unit

This block performs the lower-bound half of a pointer bounds check. It receives an instruction that has already been decoded: its prefix flags, its two opcode bytes, the ModRM byte, the REX register-extension bit, the processor mode, the default-size bit of the code segment, and an address operand. The address operand is either a register value or an effective address that address generation has already computed. The block never touches memory and has no arithmetic flags.

The block keeps a small file of bound registers, each holding a lower bound, which are loaded through a simple write port. When a recognised check instruction arrives, the block first tests it for decode legality. Three conditions make it illegal: a lock prefix, a bound index that is out of range, and 16-bit addressing outside 64-bit mode. Any of these raises an undefined-opcode fault. If the instruction is legal, the block compares the address, unsigned, against the selected lower bound. When the address is below the bound, it raises a bound-range fault and writes a failure code into a status register. Results appear one clock after the input strobe.

Top module: `lbchk_unit`

## Requirements
- R1: A check is recognised only when `in_valid` is high, `pfx_rep` is 1, `opc0` is 0x0F and `opc1` is 0x1A. Any other input produces no `out_valid` and no fault.
- R2: In 64-bit mode (`mode64`=1), a legal check raises `fault_br` exactly when the 64-bit unsigned address is strictly below the selected lower bound. An address equal to the bound passes.
- R3: In legacy mode (`mode64`=0), only bits 31:0 of the address and of the bound take part in the compare. The upper 32 bits of both are ignored.
- R4: `bnd_status` resets to 0x00. It becomes 0x01 in the same cycle that `fault_br` is asserted, and it keeps its value in every other cycle.
- R5: A recognised check with `pfx_lock`=1 raises `fault_ud`.
- R6: The bound index is `{rex_r, modrm[5:3]}` in 64-bit mode and `modrm[5:3]` in legacy mode, where `rex_r` is ignored. Any index of 4 or above raises `fault_ud`.
- R7: In legacy mode, a check raises `fault_ud` when `pfx_asz` equals `cs_d`, because that combination selects 16-bit addressing. In 64-bit mode, `pfx_asz` and `cs_d` never cause a fault.
- R8: When `fault_ud` is raised, there is no compare: `fault_br` stays low and `bnd_status` is not written. The two faults are never high together.
- R9: When `wr_en` is high, `wr_data` is loaded into bound register `wr_idx`; all bounds reset to zero. A check presented in the same cycle as a write to its register uses the bound held before that write.
- R10: `out_valid`, `fault_br` and `fault_ud` are single-cycle results that appear on the clock edge after the accepted input. They are low in every cycle that does not follow a recognised check.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Bound register write strobe |
| wr_idx | input | 2 | Bound register to write |
| wr_data | input | 64 | Lower bound value to load |
| in_valid | input | 1 | Decoded instruction present |
| pfx_rep | input | 1 | Repeat (F3) prefix present |
| pfx_lock | input | 1 | Lock prefix present |
| pfx_asz | input | 1 | Address-size override prefix present |
| rex_r | input | 1 | REX extension bit of the ModRM reg field |
| opc0 | input | 8 | First opcode byte |
| opc1 | input | 8 | Second opcode byte |
| modrm | input | 8 | ModRM byte; bits 5:3 select the bound register |
| mode64 | input | 1 | 1 = 64-bit mode, 0 = legacy mode |
| cs_d | input | 1 | Default operand/address size bit of the code segment |
| addr | input | 64 | Register value or computed effective address |
| out_valid | output | 1 | Result of a recognised check |
| fault_br | output | 1 | Bound-range fault |
| fault_ud | output | 1 | Undefined-opcode fault |
| bnd_status | output | 8 | Bound status code |

## Verification
A bound-register write and a check can land in the same cycle. This happens either on the register that the check reads or on a different one. The bench loads a bound of zero, then presents a check with an address below a new, larger bound in the same cycle that it writes that larger bound. That check must pass because it uses the old bound. An identical check on the next cycle must fault. An undefined-opcode condition can also coincide with a compare that would fail: the bench sends locked, out-of-range and 16-bit-addressing checks whose addresses lie below the bound, and it requires that only `fault_ud` rises and that `bnd_status` keeps its value.

// File: rtl/lbchk_pkg.sv
package lbchk_pkg;
   localparam logic [7:0] OPC_ESCAPE   = 8'h0F;
   localparam logic [7:0] OPC_LOWCHK   = 8'h1A;
   localparam logic [7:0] STAT_LB_FAIL = 8'h01;
   localparam int unsigned FULL_IDX_W  = 4;

   typedef struct packed {
      logic valid;
      logic ud;
      logic br;
   } lbchk_verdict_t;
endpackage

// File: rtl/lbchk_bndfile.sv
module lbchk_bndfile #(
   parameter int unsigned NUM_BND = 4,
   parameter int unsigned BND_W   = 64,
   localparam int unsigned IDX_W  = $clog2(NUM_BND)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [BND_W-1:0] wr_data,
   input  logic [IDX_W-1:0] rd_idx,
   output logic [BND_W-1:0] rd_data
);
   logic [BND_W-1:0] bnd_q [NUM_BND];

   for (genvar g = 0; g < NUM_BND; g++) begin : g_bnd
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            bnd_q[g] <= '0;
         end else if (wr_en && (wr_idx == IDX_W'(g))) begin
            bnd_q[g] <= wr_data;
         end
      end
   end

   assign rd_data = bnd_q[rd_idx];
endmodule

// File: rtl/lbchk_decode.sv
module lbchk_decode
   import lbchk_pkg::*;
#(
   parameter int unsigned NUM_BND = 4,
   localparam int unsigned IDX_W  = $clog2(NUM_BND)
) (
   input  logic             pfx_rep,
   input  logic             pfx_lock,
   input  logic             pfx_asz,
   input  logic             rex_r,
   input  logic [7:0]       opc0,
   input  logic [7:0]       opc1,
   input  logic [7:0]       modrm,
   input  logic             mode64,
   input  logic             cs_d,
   output logic             is_chk,
   output logic             illegal,
   output logic [IDX_W-1:0] bnd_sel
);
   logic [FULL_IDX_W-1:0] full_idx;
   logic                  bad_lock;
   logic                  bad_idx;
   logic                  bad_asz;

   assign is_chk   = pfx_rep && (opc0 == OPC_ESCAPE) && (opc1 == OPC_LOWCHK);
   assign full_idx = {rex_r & mode64, modrm[5:3]};
   assign bnd_sel  = full_idx[IDX_W-1:0];

   // Legality checks, in priority order; all of them map to the same fault.
   assign bad_lock = pfx_lock;
   assign bad_idx  = ({1'b0, full_idx} >= (FULL_IDX_W+1)'(NUM_BND));
   assign bad_asz  = !mode64 && (pfx_asz == cs_d);

   always_comb begin
      illegal = 1'b0;
      if (bad_lock)     illegal = 1'b1;
      else if (bad_idx) illegal = 1'b1;
      else if (bad_asz) illegal = 1'b1;
   end
endmodule

// File: rtl/lbchk_cmp.sv
module lbchk_cmp #(
   parameter int unsigned ADDR_W   = 64,
   parameter int unsigned LEGACY_W = 32
) (
   input  logic              mode64,
   input  logic [ADDR_W-1:0] addr,
   input  logic [ADDR_W-1:0] bound,
   output logic              below
);
   if (LEGACY_W == ADDR_W) begin : g_single
      assign below = addr < bound;
   end else begin : g_split
      logic below_full;
      logic below_legacy;
      assign below_full   = addr < bound;
      assign below_legacy = addr[LEGACY_W-1:0] < bound[LEGACY_W-1:0];
      assign below        = mode64 ? below_full : below_legacy;
   end
endmodule

// File: rtl/lbchk_unit.sv
module lbchk_unit
   import lbchk_pkg::*;
#(
   parameter int unsigned NUM_BND  = 4,
   parameter int unsigned ADDR_W   = 64,
   parameter int unsigned LEGACY_W = 32,
   parameter int unsigned STAT_W   = 8,
   localparam int unsigned IDX_W   = $clog2(NUM_BND)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [ADDR_W-1:0] wr_data,
   input  logic              in_valid,
   input  logic              pfx_rep,
   input  logic              pfx_lock,
   input  logic              pfx_asz,
   input  logic              rex_r,
   input  logic [7:0]        opc0,
   input  logic [7:0]        opc1,
   input  logic [7:0]        modrm,
   input  logic              mode64,
   input  logic              cs_d,
   input  logic [ADDR_W-1:0] addr,
   output logic              out_valid,
   output logic              fault_br,
   output logic              fault_ud,
   output logic [STAT_W-1:0] bnd_status
);
   if (NUM_BND < 2 || NUM_BND > 16 || (1 << IDX_W) != NUM_BND) begin : g_bad_num
      $error("NUM_BND must be a power of two between 2 and 16");
   end
   if (LEGACY_W == 0 || LEGACY_W > ADDR_W) begin : g_bad_w
      $error("LEGACY_W must be in 1..ADDR_W");
   end
   if (STAT_W < 8) begin : g_bad_s
      $error("STAT_W must hold the status code");
   end

   logic              is_chk;
   logic              illegal;
   logic [IDX_W-1:0]  bnd_sel;
   logic [ADDR_W-1:0] bound;
   logic              below;
   lbchk_verdict_t    verdict_d;
   lbchk_verdict_t    verdict_q;
   logic [STAT_W-1:0] status_q;

   lbchk_decode #(.NUM_BND(NUM_BND)) u_dec (
      .pfx_rep (pfx_rep),
      .pfx_lock(pfx_lock),
      .pfx_asz (pfx_asz),
      .rex_r   (rex_r),
      .opc0    (opc0),
      .opc1    (opc1),
      .modrm   (modrm),
      .mode64  (mode64),
      .cs_d    (cs_d),
      .is_chk  (is_chk),
      .illegal (illegal),
      .bnd_sel (bnd_sel)
   );

   lbchk_bndfile #(.NUM_BND(NUM_BND), .BND_W(ADDR_W)) u_bnd (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (wr_en),
      .wr_idx (wr_idx),
      .wr_data(wr_data),
      .rd_idx (bnd_sel),
      .rd_data(bound)
   );

   lbchk_cmp #(.ADDR_W(ADDR_W), .LEGACY_W(LEGACY_W)) u_cmp (
      .mode64(mode64),
      .addr  (addr),
      .bound (bound),
      .below (below)
   );

   always_comb begin
      verdict_d       = '0;
      verdict_d.valid = in_valid && is_chk;
      verdict_d.ud    = verdict_d.valid && illegal;
      verdict_d.br    = verdict_d.valid && !illegal && below;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         verdict_q <= '0;
         status_q  <= '0;
      end else begin
         verdict_q <= verdict_d;
         if (verdict_d.br) status_q <= STAT_W'(STAT_LB_FAIL);
      end
   end

   assign out_valid  = verdict_q.valid;
   assign fault_br   = verdict_q.br;
   assign fault_ud   = verdict_q.ud;
   assign bnd_status = status_q;
endmodule

// File: rtl/lbchk_sva.sv
module lbchk_sva (
   input logic        clk,
   input logic        rst_n,
   input logic        in_valid,
   input logic        pfx_rep,
   input logic        pfx_lock,
   input logic        mode64,
   input logic [7:0]  opc0,
   input logic [7:0]  opc1,
   input logic [7:0]  modrm,
   input logic        out_valid,
   input logic        fault_br,
   input logic        fault_ud,
   input logic [7:0]  bnd_status
);
   logic recog;
   assign recog = in_valid && pfx_rep && opc0 == 8'h0F && opc1 == 8'h1A;

   p_accept_r1: assert property (@(posedge clk) disable iff (!rst_n)
      recog |=> out_valid);
   p_reject_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !recog |=> !out_valid);
   p_status_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
      fault_br |-> bnd_status == 8'h01);
   p_status_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !fault_br |-> $stable(bnd_status));
   p_lock_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (recog && pfx_lock) |=> fault_ud);
   p_legacy_idx_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (recog && !mode64 && modrm[5]) |=> fault_ud);
   p_one_fault_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !(fault_br && fault_ud));
   p_fault_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (fault_br || fault_ud) |-> out_valid);
endmodule

bind lbchk_unit lbchk_sva u_sva (.*);

// File: tb/lbchk_unit_tb.sv
module lbchk_unit_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_idx = '0;
   logic [63:0] wr_data = '0;
   logic        in_valid = 1'b0;
   logic        pfx_rep = 1'b1;
   logic        pfx_lock = 1'b0;
   logic        pfx_asz = 1'b0;
   logic        rex_r = 1'b0;
   logic [7:0]  opc0 = 8'h0F;
   logic [7:0]  opc1 = 8'h1A;
   logic [7:0]  modrm = '0;
   logic        mode64 = 1'b1;
   logic        cs_d = 1'b1;
   logic [63:0] addr = '0;
   logic        out_valid, fault_br, fault_ud;
   logic [7:0]  bnd_status;
   int n_chk = 0;
   int n_bad = 0;

   always #4 clk = ~clk;

   lbchk_unit u_dut (.*);

   task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic defaults();
      pfx_rep = 1'b1; pfx_lock = 1'b0; pfx_asz = 1'b0; rex_r = 1'b0;
      opc0 = 8'h0F; opc1 = 8'h1A; mode64 = 1'b1; cs_d = 1'b1;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; in_valid = 1'b0; wr_en = 1'b0;
      defaults();
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic write_bnd(logic [1:0] idx, logic [63:0] val);
      @(negedge clk);
      wr_en = 1'b1; wr_idx = idx; wr_data = val;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   // Presents one check, samples the registered result after the next edge.
   task automatic run_chk(string req, logic [2:0] rsel, logic [63:0] a,
                          logic ev, logic ebr, logic eud, logic [7:0] est);
      @(negedge clk);
      in_valid = 1'b1; modrm = {2'b00, rsel, 3'b000}; addr = a;
      @(posedge clk); #1;
      check(req, "out_valid", 64'(out_valid), 64'(ev));
      check(req, "fault_br", 64'(fault_br), 64'(ebr));
      check(req, "fault_ud", 64'(fault_ud), 64'(eud));
      check(req, "bnd_status", 64'(bnd_status), 64'(est));
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   task automatic t_reset();
      do_reset();
      #1;
      check("R4", "status after reset", 64'(bnd_status), 64'h0);
      check("R10", "valid after reset", 64'(out_valid), 64'h0);
      run_chk("R9", 3'd0, 64'h0, 1, 0, 0, 8'h00);
   endtask

   task automatic t_compare64();
      do_reset();
      write_bnd(2'd1, 64'h1000_0000_0000_0000);
      run_chk("R2", 3'd1, 64'h1000_0000_0000_0000, 1, 0, 0, 8'h00);
      run_chk("R2", 3'd1, 64'h1000_0000_0000_0001, 1, 0, 0, 8'h00);
      run_chk("R2", 3'd1, 64'h0FFF_FFFF_FFFF_FFFF, 1, 1, 0, 8'h01);
      run_chk("R4", 3'd1, 64'hFFFF_FFFF_FFFF_FFFF, 1, 0, 0, 8'h01);
   endtask

   task automatic t_legacy();
      do_reset();
      write_bnd(2'd2, 64'hFFFF_FFFF_0000_1000);
      mode64 = 1'b0; cs_d = 1'b1; pfx_asz = 1'b0;
      run_chk("R3", 3'd2, 64'h0000_0001_0000_1000, 1, 0, 0, 8'h00);
      run_chk("R3", 3'd2, 64'hFFFF_FFFF_0000_0FFF, 1, 1, 0, 8'h01);
      do_reset();
      write_bnd(2'd2, 64'hFFFF_FFFF_0000_1000);
      run_chk("R3", 3'd2, 64'h0000_0000_0000_2000, 1, 1, 0, 8'h01);
   endtask

   task automatic t_lock();
      do_reset();
      write_bnd(2'd0, 64'h100);
      pfx_lock = 1'b1;
      run_chk("R5", 3'd0, 64'h10, 1, 0, 1, 8'h00);
      pfx_lock = 1'b0;
      run_chk("R8", 3'd0, 64'h10, 1, 1, 0, 8'h01);
   endtask

   task automatic t_index();
      do_reset();
      write_bnd(2'd3, 64'h100);
      mode64 = 1'b0; cs_d = 1'b1;
      run_chk("R6", 3'd4, 64'h0, 1, 0, 1, 8'h00);
      rex_r = 1'b1;
      run_chk("R6", 3'd3, 64'h200, 1, 0, 0, 8'h00);
      mode64 = 1'b1;
      run_chk("R6", 3'd3, 64'h0, 1, 0, 1, 8'h00);
      rex_r = 1'b0;
      run_chk("R8", 3'd7, 64'h0, 1, 0, 1, 8'h00);
   endtask

   task automatic t_addr_size();
      do_reset();
      write_bnd(2'd0, 64'h100);
      mode64 = 1'b0; pfx_asz = 1'b0; cs_d = 1'b0;
      run_chk("R7", 3'd0, 64'h0, 1, 0, 1, 8'h00);
      pfx_asz = 1'b1; cs_d = 1'b1;
      run_chk("R7", 3'd0, 64'h0, 1, 0, 1, 8'h00);
      pfx_asz = 1'b1; cs_d = 1'b0;
      run_chk("R7", 3'd0, 64'h200, 1, 0, 0, 8'h00);
      mode64 = 1'b1; pfx_asz = 1'b0; cs_d = 1'b0;
      run_chk("R7", 3'd0, 64'h200, 1, 0, 0, 8'h00);
   endtask

   task automatic t_recognise();
      do_reset();
      write_bnd(2'd0, 64'h100);
      pfx_rep = 1'b0;
      run_chk("R1", 3'd0, 64'h0, 0, 0, 0, 8'h00);
      pfx_rep = 1'b1; opc1 = 8'h1B;
      run_chk("R1", 3'd0, 64'h0, 0, 0, 0, 8'h00);
      opc1 = 8'h1A; opc0 = 8'h0E;
      run_chk("R1", 3'd0, 64'h0, 0, 0, 0, 8'h00);
      opc0 = 8'h0F;
   endtask

   task automatic t_timing();
      do_reset();
      write_bnd(2'd0, 64'h100);
      @(negedge clk);
      in_valid = 1'b1; modrm = 8'h00; addr = 64'h10;
      @(posedge clk); #1;
      check("R10", "fault one edge later", 64'(fault_br), 64'h1);
      @(negedge clk);
      in_valid = 1'b0;
      @(posedge clk); #1;
      check("R10", "valid drops", 64'(out_valid), 64'h0);
      check("R10", "fault drops", 64'(fault_br), 64'h0);
   endtask

   task automatic t_same_cycle();
      do_reset();
      @(negedge clk);
      wr_en = 1'b1; wr_idx = 2'd3; wr_data = 64'h100;
      in_valid = 1'b1; modrm = {2'b00, 3'd3, 3'b000}; addr = 64'h50;
      @(posedge clk); #1;
      check("R9", "same-cycle uses old bound", 64'(fault_br), 64'h0);
      @(negedge clk);
      wr_en = 1'b0; in_valid = 1'b0;
      run_chk("R9", 3'd3, 64'h50, 1, 1, 0, 8'h01);
   endtask

   initial begin
      t_reset();
      t_compare64();
      t_legacy();
      t_lock();
      t_index();
      t_addr_size();
      t_recognise();
      t_timing();
      t_same_cycle();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL R10 watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule